// File: doc/BRIEF.md
# DMA Global Control and Status Register

This block is the single global control/status word of a multi-channel DMA controller. Software reads and writes it through a plain strobe-based CPU port. Hardware sets its error flags: an address-error event and a non-maskable-interrupt event from the DMA engine, plus a status event for bit 4. The block sends the engine a gated enable, a channel-priority mode field and an on-demand mode bit. It also drives a mask that the channel-0 configuration registers use to refuse CPU writes, and the channel-0 acknowledge pin with its polarity adjusted.

A hardware-set flag cannot be cleared by a blind write. Software must first read the register and see the flag as 1. After that, a write carrying 0 in that bit position clears the flag. Any write ends this read-then-clear window, whether or not it clears anything. While either flag is set, the enable sent to the engine is forced low, so every channel stops until software clears the flag. In on-demand mode the channel-0 configuration writes are blocked and the acknowledge pin becomes active low.

Top module: `dma_glb_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) makes every readable bit 0 on the following cycle, which clears the enable, the mode fields and all flags, and ends any pending read-then-clear window.
- R2: Bits 31:16, 14:10, 7:5 and 3 always read 0, and writing 1 to them has no effect on any readable bit.
- R3: Bit 0 (master enable) and bits 9:8 (priority mode, driven on `prio_mode`) take the written value on the cycle after a write.
- R4: Bit 15 (on-demand mode) takes the written value on the cycle after a write, and `ch0_cfg_wr_mask` is 1 exactly while bit 15 is 1.
- R5: `ch0_ack_pin` equals `ch0_ack` while bit 15 is 0, and equals its inverse while bit 15 is 1.
- R6: A pulse on `addr_err_evt` sets bit 2, and a pulse on `nmi_evt` sets bit 1, on the following cycle. Writing 1 to either bit never changes it.
- R7: A write with 0 in bit 2 (or bit 1) clears that flag only if a read (`cpu_rd`) returned the flag as 1 after the last write. Any write ends that window, so a second clearing write without a new read leaves the flag set.
- R8: If a flag's set event arrives in the same cycle as a write that would clear that flag, the flag stays 1.
- R9: `dma_en` is 1 only while bit 0 is 1 and bits 2 and 1 are both 0.
- R10: A pulse on `cod_evt` sets bit 4. With `COD_WR_EN`=1, a write with 0 in bit 4 clears it without needing a prior read. With `COD_WR_EN`=0, writes never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on or manual) |
| cpu_rd | input | 1 | CPU read strobe; opens the read-then-clear window for flags read as 1 |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | Current register value |
| addr_err_evt | input | 1 | Address-error set event from the engine |
| nmi_evt | input | 1 | NMI set event |
| cod_evt | input | 1 | Set event for the bit 4 status flag |
| ch0_ack | input | 1 | Channel-0 acknowledge from the engine, active high |
| dma_en | output | 1 | Enable to all channels, gated by the flags |
| prio_mode | output | PRIO_W | Channel-priority mode field |
| ondemand | output | 1 | On-demand transfer mode |
| ch0_cfg_wr_mask | output | 1 | Blocks CPU writes to the channel-0 configuration registers |
| ch0_ack_pin | output | 1 | Channel-0 acknowledge pin with mode-dependent polarity |

## Verification
The assertions check the following on every cycle: the reserved bits read as zero, the flag-gating of `dma_en`, the mask and acknowledge polarity, and that a flag set event is seen one cycle later. They also check that a flag only falls after a write carrying 0 in its position, and that a set event beats a clearing write. Whether a read actually came before that write, and whether a write ended the window, depends on history a simple property cannot carry. Those cases are shown by the bench's directed sequences. The bench's sequences also cover write-1 immunity and the two build variants of bit 4.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
  localparam int EN_BIT   = 0;
  localparam int NMI_BIT  = 1;
  localparam int AE_BIT   = 2;
  localparam int COD_BIT  = 4;
  localparam int PRIO_LSB = 8;
  localparam int OD_BIT   = 15;
  localparam int NFLAG    = 2;

  function automatic int flag_pos(input int idx);
    return (idx == 0) ? NMI_BIT : AE_BIT;
  endfunction
endpackage

// File: rtl/dgc_flag.sv
module dgc_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic rd,
  input  logic wr,
  input  logic wbit,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (set_evt)
        flag <= 1'b1;
      else if (wr && !wbit && armed)
        flag <= 1'b0;
      if (wr)
        armed <= 1'b0;
      else if (rd && flag)
        armed <= 1'b1;
    end
  end
endmodule

// File: rtl/dgc_cfg.sv
module dgc_cfg #(
  parameter int DW        = 32,
  parameter int PRIO_W    = 2,
  parameter bit COD_WR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  input  logic              cod_evt,
  output logic              en,
  output logic [PRIO_W-1:0] prio,
  output logic              od,
  output logic              cod
);
  import dgc_pkg::*;

  localparam logic [DW-1:0] PRIO_MASK = ((DW'(1) << PRIO_W) - DW'(1)) << PRIO_LSB;
  localparam logic [DW-1:0] USED_MASK = PRIO_MASK | (DW'(1) << EN_BIT)
                                      | (DW'(1) << OD_BIT) | (DW'(1) << COD_BIT);

  logic unused_wbits;
  assign unused_wbits = ^(wdata & ~USED_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      prio <= '0;
      od   <= 1'b0;
    end else if (wr) begin
      en   <= wdata[EN_BIT];
      prio <= wdata[PRIO_LSB +: PRIO_W];
      od   <= wdata[OD_BIT];
    end
  end

  generate
    if (COD_WR_EN) begin : g_cod_rw
      always_ff @(posedge clk) begin
        if (rst)                          cod <= 1'b0;
        else if (cod_evt)                 cod <= 1'b1;
        else if (wr && !wdata[COD_BIT])   cod <= 1'b0;
      end
    end else begin : g_cod_ro
      always_ff @(posedge clk) begin
        if (rst)          cod <= 1'b0;
        else if (cod_evt) cod <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/dma_glb_ctrl.sv
module dma_glb_ctrl #(
  parameter int DW        = 32,
  parameter int PRIO_W    = 2,
  parameter bit COD_WR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  input  logic              addr_err_evt,
  input  logic              nmi_evt,
  input  logic              cod_evt,
  input  logic              ch0_ack,
  output logic              dma_en,
  output logic [PRIO_W-1:0] prio_mode,
  output logic              ondemand,
  output logic              ch0_cfg_wr_mask,
  output logic              ch0_ack_pin
);
  import dgc_pkg::*;

  logic [NFLAG-1:0] flag_evt;
  logic [NFLAG-1:0] flag_q;
  logic             en_q, od_q, cod_q;
  logic [PRIO_W-1:0] prio_q;

  assign flag_evt[0] = nmi_evt;
  assign flag_evt[1] = addr_err_evt;

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      dgc_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_evt(flag_evt[i]),
        .rd     (cpu_rd),
        .wr     (cpu_wr),
        .wbit   (cpu_wdata[flag_pos(i)]),
        .flag   (flag_q[i])
      );
    end
  endgenerate

  dgc_cfg #(.DW(DW), .PRIO_W(PRIO_W), .COD_WR_EN(COD_WR_EN)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr     (cpu_wr),
    .wdata  (cpu_wdata),
    .cod_evt(cod_evt),
    .en     (en_q),
    .prio   (prio_q),
    .od     (od_q),
    .cod    (cod_q)
  );

  always_comb begin
    cpu_rdata                          = '0;
    cpu_rdata[EN_BIT]                  = en_q;
    cpu_rdata[COD_BIT]                 = cod_q;
    cpu_rdata[PRIO_LSB +: PRIO_W]      = prio_q;
    cpu_rdata[OD_BIT]                  = od_q;
    for (int i = 0; i < NFLAG; i++)
      cpu_rdata[flag_pos(i)]           = flag_q[i];
  end

  assign dma_en          = en_q & ~(|flag_q);
  assign prio_mode       = prio_q;
  assign ondemand        = od_q;
  assign ch0_cfg_wr_mask = od_q;
  assign ch0_ack_pin     = ch0_ack ^ od_q;
endmodule

// File: rtl/dgc_sva.sv
module dgc_sva #(
  parameter int DW     = 32,
  parameter int PRIO_W = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_wr,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic          addr_err_evt,
  input logic          nmi_evt,
  input logic          ch0_ack,
  input logic          dma_en,
  input logic          ch0_cfg_wr_mask,
  input logic          ch0_ack_pin
);
  import dgc_pkg::*;

  localparam logic [DW-1:0] LIVE = (((DW'(1) << PRIO_W) - DW'(1)) << PRIO_LSB)
    | (DW'(1) << EN_BIT) | (DW'(1) << NMI_BIT) | (DW'(1) << AE_BIT)
    | (DW'(1) << COD_BIT) | (DW'(1) << OD_BIT);

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cpu_rdata == '0);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (cpu_rdata & ~LIVE) == '0);

  a_r3_enable_written: assert property (@(posedge clk) disable iff (rst)
    cpu_wr |=> cpu_rdata[EN_BIT] == $past(cpu_wdata[EN_BIT]));

  a_r4_mask_follows_mode: assert property (@(posedge clk) disable iff (rst)
    ch0_cfg_wr_mask == cpu_rdata[OD_BIT]);

  a_r5_ack_polarity: assert property (@(posedge clk) disable iff (rst)
    ch0_ack_pin == (ch0_ack ^ cpu_rdata[OD_BIT]));

  a_r6_ae_set: assert property (@(posedge clk) disable iff (rst)
    addr_err_evt |=> cpu_rdata[AE_BIT]);

  a_r6_nmi_set: assert property (@(posedge clk) disable iff (rst)
    nmi_evt |=> cpu_rdata[NMI_BIT]);

  a_r7_ae_falls_on_zero_write: assert property (@(posedge clk) disable iff (rst)
    ($fell(cpu_rdata[AE_BIT]) && !$past(rst)) |-> ($past(cpu_wr) && !$past(cpu_wdata[AE_BIT])));

  a_r7_nmi_falls_on_zero_write: assert property (@(posedge clk) disable iff (rst)
    ($fell(cpu_rdata[NMI_BIT]) && !$past(rst)) |-> ($past(cpu_wr) && !$past(cpu_wdata[NMI_BIT])));

  a_r8_set_wins_nmi: assert property (@(posedge clk) disable iff (rst)
    (nmi_evt && cpu_wr && !cpu_wdata[NMI_BIT]) |=> cpu_rdata[NMI_BIT]);

  a_r9_flags_halt: assert property (@(posedge clk) disable iff (rst)
    (cpu_rdata[AE_BIT] || cpu_rdata[NMI_BIT]) |-> !dma_en);
endmodule

bind dma_glb_ctrl dgc_sva #(.DW(DW), .PRIO_W(PRIO_W)) u_sva (
  .clk            (clk),
  .rst            (rst),
  .cpu_wr         (cpu_wr),
  .cpu_wdata      (cpu_wdata),
  .cpu_rdata      (cpu_rdata),
  .addr_err_evt   (addr_err_evt),
  .nmi_evt        (nmi_evt),
  .ch0_ack        (ch0_ack),
  .dma_en         (dma_en),
  .ch0_cfg_wr_mask(ch0_cfg_wr_mask),
  .ch0_ack_pin    (ch0_ack_pin)
);

// File: tb/dma_glb_ctrl_bench.sv
module dma_glb_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic        addr_err_evt = 1'b0, nmi_evt = 1'b0, cod_evt = 1'b0, ch0_ack = 1'b0;

  logic [31:0] rdata_a, rdata_b;
  logic        en_a, en_b, od_a, od_b, mask_a, mask_b, pin_a, pin_b;
  logic [1:0]  prio_a, prio_b;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_glb_ctrl u_dma_glb_ctrl (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(rdata_a), .addr_err_evt(addr_err_evt), .nmi_evt(nmi_evt),
    .cod_evt(cod_evt), .ch0_ack(ch0_ack), .dma_en(en_a), .prio_mode(prio_a),
    .ondemand(od_a), .ch0_cfg_wr_mask(mask_a), .ch0_ack_pin(pin_a));

  dma_glb_ctrl #(.COD_WR_EN(1'b0)) u_dma_glb_ctrl_ro (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(rdata_b), .addr_err_evt(addr_err_evt), .nmi_evt(nmi_evt),
    .cod_evt(cod_evt), .ch0_ack(ch0_ack), .dma_en(en_b), .prio_mode(prio_b),
    .ondemand(od_b), .ch0_cfg_wr_mask(mask_b), .ch0_ack_pin(pin_b));

  // behavioural reference model
  int m_en, m_prio, m_od, m_ae, m_nmi, m_arm_ae, m_arm_nmi, m_cod_a, m_cod_b;

  function automatic logic [31:0] model_word(input int cod);
    return (m_od << 15) | (m_prio << 8) | (cod << 4) | (m_ae << 2) | (m_nmi << 1) | m_en;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_prio = 0; m_od = 0; m_ae = 0; m_nmi = 0;
      m_arm_ae = 0; m_arm_nmi = 0; m_cod_a = 0; m_cod_b = 0;
    end else begin
      int ae_n, nmi_n;
      ae_n  = addr_err_evt ? 1 : ((cpu_wr && !cpu_wdata[2] && m_arm_ae  != 0) ? 0 : m_ae);
      nmi_n = nmi_evt      ? 1 : ((cpu_wr && !cpu_wdata[1] && m_arm_nmi != 0) ? 0 : m_nmi);
      if (cpu_wr) begin m_arm_ae = 0; m_arm_nmi = 0; end
      else if (cpu_rd) begin
        if (m_ae  != 0) m_arm_ae  = 1;
        if (m_nmi != 0) m_arm_nmi = 1;
      end
      m_ae = ae_n; m_nmi = nmi_n;
      if (cod_evt) begin m_cod_a = 1; m_cod_b = 1; end
      else if (cpu_wr && !cpu_wdata[4]) m_cod_a = 0;
      if (cpu_wr) begin
        m_en = cpu_wdata[0]; m_prio = cpu_wdata[9:8]; m_od = cpu_wdata[15];
      end
    end
    #(CLK_PERIOD/4);
    if (!done) begin
      chk("R2 rdata", rdata_a, model_word(m_cod_a));
      chk("R10 rdata_ro", rdata_b, model_word(m_cod_b));
      chk("R9 dma_en", {31'b0, en_a}, (m_en != 0 && m_ae == 0 && m_nmi == 0) ? 1 : 0);
      chk("R3 prio", {30'b0, prio_a}, m_prio);
      chk("R4 mask", {31'b0, mask_a}, m_od);
      chk("R5 pin", {31'b0, pin_a}, {31'b0, ch0_ack ^ (m_od != 0)});
    end
  end

  task automatic do_wr(input logic [31:0] d);
    cpu_wr = 1'b1; cpu_wdata = d;
    @(posedge clk); @(negedge clk);
    cpu_wr = 1'b0; cpu_wdata = '0; nmi_evt = 1'b0;
  endtask

  task automatic do_rd();
    cpu_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: addr_err_evt = 1'b1;
      1: nmi_evt = 1'b1;
      default: cod_evt = 1'b1;
    endcase
    @(posedge clk); @(negedge clk);
    addr_err_evt = 1'b0; nmi_evt = 1'b0; cod_evt = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset word", rdata_a, 32'h0);
    do_wr(32'hFFFF_FFFF);
    chk("R2 R3 R4 all-ones write", rdata_a, 32'h0000_8301);
    chk("R4 mask on", {31'b0, mask_a}, 32'h1);
    ch0_ack = 1'b1; #1;
    chk("R5 ack low-active", {31'b0, pin_a}, 32'h0);
    do_wr(32'h0000_0001);
    chk("R5 ack high-active", {31'b0, pin_a}, 32'h1);
    ch0_ack = 1'b0;
    chk("R9 enabled", {31'b0, en_a}, 32'h1);
    pulse(0);
    chk("R6 ae set", rdata_a, 32'h5);
    chk("R9 halted", {31'b0, en_a}, 32'h0);
    do_wr(32'h1);
    chk("R7 blind clear ignored", rdata_a, 32'h5);
    do_rd();
    do_wr(32'h1);
    chk("R7 read then clear", rdata_a, 32'h1);
    pulse(1);
    do_wr(32'h3);
    chk("R6 write one no effect", rdata_a, 32'h3);
    do_rd();
    do_wr(32'h3);
    do_wr(32'h1);
    chk("R7 window consumed", rdata_a, 32'h3);
    do_rd();
    nmi_evt = 1'b1;
    do_wr(32'h1);
    chk("R8 set beats clear", rdata_a, 32'h3);
    do_rd();
    do_wr(32'h1);
    chk("R7 nmi cleared", rdata_a, 32'h1);
    pulse(2);
    chk("R10 cod set", rdata_a, 32'h11);
    do_wr(32'h1);
    chk("R10 cod cleared", rdata_a, 32'h1);
    chk("R10 cod read-only build", rdata_b, 32'h11);
    do_wr(32'h8201);
    pulse(0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1 reset mid-run", rdata_a, 32'h0);
    chk("R1 reset ro", rdata_b, 32'h0);
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule